// File: doc/BRIEF.md
# Match Output and PWM Unit

This unit drives the match output lines of a general-purpose timer. For each channel it receives a one-cycle match pulse and the live timer count from the timer core, together with that channel's compare value. In normal mode, each channel's output is held in a level bit that changes only when that channel's own match fires. A 2-bit action code chosen by software sets what the change is. In PWM mode, a per-channel enable hands the output to a compare of the live count against the channel's compare value. The output is low below that value and high at or above it. Software normally lets one channel (channel 3 by convention) end each period by resetting the timer. That reset pulls the other outputs low again.

Software reaches the unit through a small register port with a write strobe and a read port whose data is available in the same cycle. The level/action register sits at offset 0x3C and the PWM enable register at offset 0x74, and both are zero after reset. The timer count, the compare values and the period reset all belong to the timer core.

Top module: `match_out_unit`

## Requirements
- R1: After reset, every output is low and both registers read back as zero.
- R2: The register at 0x3C reads the output levels of channels 0..NCH-1 in bits NCH-1:0 and the action code of channel n in bits 2n+5:2n+4. The register at 0x74 reads the PWM enables in bits NCH-1:0. All other bits, and every other address, read as zero.
- R3: Action codes are 0 = keep, 1 = drive low, 2 = drive high and 3 = invert. On a match pulse for channel n, the code of channel n is applied to its level bit, and the new level appears on the output in the next cycle.
- R4: A match pulse changes only the level of its own channel.
- R5: A write to 0x3C loads the level bits from wdata bits NCH-1:0, with the change visible in the next cycle.
- R6: When a software write to 0x3C and a match pulse with a non-zero action code hit the same channel in the same cycle, the match action decides that channel's level. A channel whose code is 0 takes the written value.
- R7: With PWM enabled on channel n, output n is low in the cycle after the timer count was below compare value n. It is high in the cycle after the count was equal to or above compare value n.
- R8: With a PWM enable at 0, that output follows its level bit. Match actions keep updating the level bit while PWM is enabled, and the level bit reaches the output as soon as PWM is turned off.
- R9: With all PWM enables and all action codes at 0, and no write to 0x3C, match pulses and timer movement never change any output.
- R10: A write to any address other than 0x3C and 0x74 changes no register and no output. Bits of wdata above the action fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_pulse | input | NCH | One-cycle match strobe per channel from the timer core |
| timer_val | input | TW | Live timer count |
| match_val | input | NCH*TW | Compare value per channel, channel n at bits n*TW +: TW |
| reg_addr | input | AW | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, valid in the same cycle as reg_addr |
| match_out | output | NCH | Match output levels |

## Verification
A wrong level bit shows on match_out in the very next cycle when its PWM enable is off, and it also shows in the readback at 0x3C. A wrong level bit stays hidden behind an active PWM enable until PWM is turned off. A corrupted action code shows nothing until that channel's next match pulse, so the bench pulses every channel under each of the four codes. A wrong compare level register shows within one cycle in PWM mode, so the count is walked across the compare value one step at a time.

// File: rtl/mo_pkg.sv
package mo_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } mo_act_e;

    typedef struct packed {
        logic lvl;   // registered compare result for PWM mode
        logic em;    // match-driven level bit
    } mo_chan_st_t;
endpackage

// File: rtl/mo_chan.sv
module mo_chan
    import mo_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    act_i,
    input  logic          match_i,
    input  logic          sw_we_i,
    input  logic          sw_val_i,
    input  logic [TW-1:0] timer_i,
    input  logic [TW-1:0] mval_i,
    input  logic          pwm_en_i,
    output logic          em_o,
    output logic          pin_o
);
    timeunit 1ns;
    timeprecision 1ps;

    mo_act_e     act;
    mo_chan_st_t st_d, st_q;
    logic        hw_hit;

    assign act    = mo_act_e'(act_i);
    assign hw_hit = match_i && (act != ACT_KEEP);

    always_comb begin
        st_d = st_q;
        if (hw_hit) begin
            case (act)
                ACT_LOW:  st_d.em = 1'b0;
                ACT_HIGH: st_d.em = 1'b1;
                ACT_FLIP: st_d.em = ~st_q.em;
                default:  st_d.em = st_q.em;
            endcase
        end else if (sw_we_i) begin
            st_d.em = sw_val_i;
        end
        st_d.lvl = (timer_i >= mval_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign em_o  = st_q.em;
    assign pin_o = pwm_en_i ? st_q.lvl : st_q.em;

    // R3
    act_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act == ACT_HIGH) |=> em_o);
    // R3
    act_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act == ACT_LOW) |=> !em_o);
    // R3
    act_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && act == ACT_FLIP) |=> (em_o != $past(em_o)));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_hit && !sw_we_i) |=> $stable(em_o));
    // R6
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_i && !hw_hit) |=> (em_o == $past(sw_val_i)));
    // R7
    pwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && (timer_i < mval_i)) |=> (!pwm_en_i || !pin_o));
    // R7
    pwm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && (timer_i >= mval_i)) |=> (!pwm_en_i || pin_o));
endmodule

// File: rtl/mo_regif.sv
module mo_regif #(
    parameter int          NCH     = 4,
    parameter int          AW      = 8,
    parameter int          DW      = 32,
    parameter logic [AW-1:0] EM_OFS  = 8'h3C,
    parameter logic [AW-1:0] PWM_OFS = 8'h74
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr_i,
    input  logic           wen_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [NCH-1:0] em_i,
    output logic [2*NCH-1:0] act_o,
    output logic [NCH-1:0] pwm_o,
    output logic           em_we_o,
    output logic [NCH-1:0] em_wdata_o,
    output logic [DW-1:0]  rdata_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ACT_LSB = NCH;
    localparam int ACT_W   = 2 * NCH;
    localparam int USED_W  = ACT_LSB + ACT_W;

    typedef struct packed {
        logic [ACT_W-1:0] act;
        logic [NCH-1:0]   pwm;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    em_sel, pwm_sel;
    logic    unused_hi;

    assign em_sel    = (addr_i == EM_OFS);
    assign pwm_sel   = (addr_i == PWM_OFS);
    assign unused_hi = ^wdata_i[DW-1:USED_W];

    always_comb begin
        st_d = st_q;
        if (wen_i && em_sel)  st_d.act = wdata_i[ACT_LSB +: ACT_W];
        if (wen_i && pwm_sel) st_d.pwm = wdata_i[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (em_sel) begin
            rdata_o[NCH-1:0]          = em_i;
            rdata_o[ACT_LSB +: ACT_W] = st_q.act;
        end else if (pwm_sel) begin
            rdata_o[NCH-1:0] = st_q.pwm;
        end
    end

    assign act_o      = st_q.act;
    assign pwm_o      = st_q.pwm;
    assign em_we_o    = wen_i && em_sel;
    assign em_wdata_o = wdata_i[NCH-1:0];

    // R8
    pwm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && pwm_sel) |=> (pwm_o == $past(wdata_i[NCH-1:0])));
    // R10
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_i && !em_sel && !pwm_sel) |=> ($stable(act_o) && $stable(pwm_o)));
endmodule

// File: rtl/match_out_unit.sv
module match_out_unit #(
    parameter int            NCH     = 4,
    parameter int            TW      = 32,
    parameter int            AW      = 8,
    parameter int            DW      = 32,
    parameter logic [AW-1:0] EM_OFS  = 8'h3C,
    parameter logic [AW-1:0] PWM_OFS = 8'h74
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    match_pulse,
    input  logic [TW-1:0]     timer_val,
    input  logic [NCH*TW-1:0] match_val,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wen,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NCH-1:0]    match_out
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2*NCH-1:0] act;
    logic [NCH-1:0]   pwm_en;
    logic [NCH-1:0]   em_lvl;
    logic [NCH-1:0]   em_wdata;
    logic             em_we;

    mo_regif #(
        .NCH(NCH), .AW(AW), .DW(DW), .EM_OFS(EM_OFS), .PWM_OFS(PWM_OFS)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr),
        .wen_i      (reg_wen),
        .wdata_i    (reg_wdata),
        .em_i       (em_lvl),
        .act_o      (act),
        .pwm_o      (pwm_en),
        .em_we_o    (em_we),
        .em_wdata_o (em_wdata),
        .rdata_o    (reg_rdata)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        mo_chan #(.TW(TW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act[2*n +: 2]),
            .match_i  (match_pulse[n]),
            .sw_we_i  (em_we),
            .sw_val_i (em_wdata[n]),
            .timer_i  (timer_val),
            .mval_i   (match_val[n*TW +: TW]),
            .pwm_en_i (pwm_en[n]),
            .em_o     (em_lvl[n]),
            .pin_o    (match_out[n])
        );
    end

    // R9
    quiet_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en == '0 && act == '0 && !em_we) |=> $stable(match_out));
endmodule

// File: tb/match_out_unit_test.sv
module match_out_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 4;
    localparam int TW  = 32;
    localparam int AW  = 8;
    localparam int DW  = 32;
    localparam logic [AW-1:0] A_EM  = 8'h3C;
    localparam logic [AW-1:0] A_PWM = 8'h74;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    match_pulse = '0;
    logic [TW-1:0]     timer_val = '0;
    logic [NCH*TW-1:0] match_val = '0;
    logic [AW-1:0]     reg_addr = '0;
    logic              reg_wen = 1'b0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic [NCH-1:0]    match_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    match_out_unit uut (
        .clk(clk), .rst_n(rst_n), .match_pulse(match_pulse),
        .timer_val(timer_val), .match_val(match_val),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .match_out(match_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wen = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk);
        match_pulse = m;
        @(negedge clk);
        match_pulse = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 outputs", 32'(match_out), 32'h0);
        rd(A_EM, d);  chk("R1 level/action reg", d, 32'h0);
        rd(A_PWM, d); chk("R1 pwm reg", d, 32'h0);
    endtask

    task automatic t_actions();
        logic [DW-1:0] d;
        // ch0 HIGH(2), ch1 LOW(1), ch2 FLIP(3), ch3 KEEP(0), levels 0010
        wr(A_EM, 32'h0000_0362);
        chk("R5 initial levels", 32'(match_out), 32'h2);
        rd(A_EM, d); chk("R2 action field readback", d, 32'h362);
        pulse(4'b1111);
        chk("R3 four codes first pulse", 32'(match_out), 32'h5);
        pulse(4'b1111);
        chk("R3 four codes second pulse", 32'(match_out), 32'h1);
    endtask

    task automatic t_indep();
        pulse(4'b0100);
        chk("R4 only channel 2 moves", 32'(match_out), 32'h5);
    endtask

    task automatic t_sw();
        wr(A_EM, 32'h0000_036A);
        chk("R5 software load", 32'(match_out), 32'hA);
    endtask

    task automatic t_prio();
        @(negedge clk);
        reg_addr = A_EM; reg_wen = 1'b1; reg_wdata = 32'h0000_0368;
        match_pulse = 4'b1001;
        @(negedge clk);
        reg_wen = 1'b0; match_pulse = '0;
        // ch0 HIGH beats written 0; ch3 KEEP takes written 1
        chk("R6 match beats write", 32'(match_out), 32'h9);
    endtask

    task automatic t_pwm();
        wr(A_PWM, 32'h0000_0002);
        match_val[1*TW +: TW] = 32'd10;
        @(negedge clk); timer_val = 32'd9;
        @(negedge clk); chk("R7 below compare", 32'(match_out), 32'h9);
        timer_val = 32'd10;
        @(negedge clk); chk("R7 equal compare", 32'(match_out), 32'hB);
        timer_val = 32'd11;
        @(negedge clk); chk("R7 above compare", 32'(match_out), 32'hB);
        timer_val = 32'd0;
        @(negedge clk); chk("R7 period restart low", 32'(match_out), 32'h9);
    endtask

    task automatic t_mux();
        logic [DW-1:0] d;
        wr(A_PWM, 32'h0000_0006);
        match_val[2*TW +: TW] = 32'd100;
        @(negedge clk);
        chk("R8 pwm hides level", 32'(match_out), 32'h9);
        pulse(4'b0100);
        chk("R8 output held by pwm", 32'(match_out), 32'h9);
        rd(A_EM, d); chk("R8 level still updated", d, 32'h36D);
        wr(A_PWM, 32'h0);
        chk("R8 level back on output", 32'(match_out), 32'hD);
    endtask

    task automatic t_quiet();
        wr(A_EM, 32'h0);
        wr(A_PWM, 32'h0);
        chk("R9 cleared", 32'(match_out), 32'h0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            match_pulse = 4'(i * 7 + 3);
            timer_val = 32'(i * 13);
            match_val = {4{32'(i)}};
            @(negedge clk);
            chk("R9 no change", 32'(match_out), 32'h0);
        end
        match_pulse = '0; timer_val = '0;
    endtask

    task automatic t_stray();
        logic [DW-1:0] d;
        wr(A_EM, 32'h0000_0092);   // ch0 LOW, ch1 FLIP? no: ch0=1(LOW) ch1=2(HIGH), level bit1
        chk("R5 reload", 32'(match_out), 32'h2);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R10 outputs after stray writes", 32'(match_out), 32'h2);
        rd(A_EM, d);  chk("R10 level/action unchanged", d, 32'h92);
        rd(A_PWM, d); chk("R10 pwm unchanged", d, 32'h0);
        rd(8'h40, d); chk("R2 unmapped reads zero", d, 32'h0);
        wr(A_EM, 32'hFFFF_F000);
        rd(A_EM, d);  chk("R10 upper wdata ignored", d, 32'h0);
        wr(A_PWM, 32'hFFFF_FFF5);
        rd(A_PWM, d); chk("R2 pwm upper bits read zero", d, 32'h5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_actions();
        t_indep();
        t_sw();
        t_prio();
        t_pwm();
        t_mux();
        t_quiet();
        t_stray();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule